// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block is the status-read logic in a NOR-style flash controller. It follows the internal state of an embedded operation. The states are idle, programming, the sector-erase acceptance window, erasing, suspended erase with reads allowed, suspended erase with a program running, and a locked failure state. On every read strobe it returns a status byte. The byte is built from the current mode, from the read address, and from the set of sectors chosen for erase.

The block takes single-cycle command strobes: program, sector erase, suspend, resume and reset. With them come a command address, the most significant bit of the program data, and a flag that says whether the target location is blank. A pulse tick stands for one internal program or erase pulse. Progress is counted in ticks, and the count is checked against fixed pulse limits. The array contents are supplied on `array_dout`. The block returns them in place of status whenever no status is due. A busy output is high while an operation holds the device.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `stat_out` is 0x00 and `stat_vld` and `busy` are 0. Each read strobe gives `stat_vld` high on the next cycle, together with the byte for that read. In idle a read returns `array_dout`.
- R2: A program command on a blank target sets `busy`. Status reads then give bit 7 = inverted data bit 7, bit 6 toggling, bit 5 = 0, bit 3 = 0, bit 2 = 1, and bits 4, 1 and 0 = 0. After PGM_PULSES ticks the block returns to idle.
- R3: When the target is not blank, the program never completes. At the PGM_LIMIT-th tick bit 5 becomes 1 and `busy` stays 1. Failure reads give bit 7 = inverted data (0 for a failed erase), bit 6 toggling, and bits 3 and 2 = 0.
- R4: In the failure state, program and erase commands are ignored. Only a reset command returns the block to idle.
- R5: The first sector-erase command opens a window of ERASE_WIN cycles. During the window, reads give bit 7 = 0 and bit 3 = 0. Once the erase proper starts, bit 3 reads 1.
- R6: A sector-erase command inside the window adds its sector (address bits [ADDR_W-1 -: SECT_W]) to the erase set and restarts the window.
- R7: While erasing, program, erase and reset commands are ignored.
- R8: During the window and during erase, bit 6 toggles on every read. Bit 2 toggles on reads from a selected sector and reads 1 on reads from other sectors.
- R9: Erase ends after (selected sectors × ERS_PULSES) ticks and returns to idle. If that product exceeds ERS_LIMIT, the failure state is entered at the ERS_LIMIT-th tick, with bit 7 = 0.
- R10: Suspend during erase clears `busy`. A read from a selected sector gives bit 7 = 1, bit 6 steady, bit 3 = 1 and bit 2 toggling. A read from any other sector returns `array_dout`.
- R11: In suspend, a program to a non-selected sector gives status bit 7 = inverted data, bit 6 toggling, bit 3 = 1 and bit 2 = 1. It returns to suspend after PGM_PULSES ticks. A program to a selected sector is ignored.
- R12: Resume returns the block to erase with its tick count preserved.
- R13: Toggle bits change only on read strobes, never on idle clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_prog | input | 1 | Program command strobe |
| cmd_erase | input | 1 | Sector-erase command strobe |
| cmd_susp | input | 1 | Erase-suspend strobe |
| cmd_resume | input | 1 | Erase-resume strobe |
| cmd_reset | input | 1 | Reset command strobe |
| cmd_addr | input | ADDR_W | Address carried with a command |
| pgm_bit7 | input | 1 | Bit 7 of the data being programmed |
| tgt_blank | input | 1 | Program target is erased |
| pulse_tick | input | 1 | One internal program/erase pulse |
| rd_stb | input | 1 | Status read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_dout | input | 8 | Array data for non-status reads |
| stat_out | output | 8 | Returned byte |
| stat_vld | output | 1 | `stat_out` holds a new read result |
| busy | output | 1 | Operation holds the device |

## Verification
Every read result is due exactly one cycle after its strobe. The bench queues the expected byte when it drives the strobe. A monitor pops and compares that byte on the falling edge on which `stat_vld` is high. A command or tick takes effect at the next rising edge. The bench therefore samples `busy` and issues the next read on the falling edge that follows, and it counts window cycles from that edge. Window and limit checks keep clear of the exact boundary cycle, so the result reflects the requirement and not the sampling phase.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PROG  = 3'd1,
    M_EWIN  = 3'd2,
    M_ERASE = 3'd3,
    M_SREAD = 3'd4,
    M_SPROG = 3'd5,
    M_FAIL  = 3'd6
  } mode_t;

  // Status byte layout: b7 data-poll, b6 toggle, b5 limit, b3 window, b2 sector toggle
  function automatic logic [7:0] pack_status(input logic b7, input logic b6,
                                             input logic b5, input logic b3,
                                             input logic b2);
    return {b7, b6, b5, 1'b0, b3, b2, 2'b00};
  endfunction

  // Total erase pulses for a selected sector count
  function automatic int unsigned erase_need(input int unsigned nsel,
                                             input int unsigned per_sect);
    return nsel * per_sect;
  endfunction

  // True when the tick arriving now brings the count to the goal
  function automatic logic tick_hits(input int unsigned cnt_now,
                                     input int unsigned goal);
    return (cnt_now + 1) == goal;
  endfunction

endpackage

// File: rtl/fsg_erase_set.sv
module fsg_erase_set
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SECT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 add,
  input  logic                 clear,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 cmd_hit,
  output logic                 rd_hit,
  output logic [$clog2((1<<SECT_W)+1)-1:0] sel_cnt
);
  localparam int unsigned NSECT = 1 << SECT_W;
  localparam int unsigned CNT_W = $clog2(NSECT + 1);

  logic [NSECT-1:0]  mask_q;
  logic [SECT_W-1:0] cmd_sect;
  logic [SECT_W-1:0] rd_sect;
  logic [NSECT-1:0]  cmd_onehot;

  assign cmd_sect   = cmd_addr[ADDR_W-1 -: SECT_W];
  assign rd_sect    = rd_addr[ADDR_W-1 -: SECT_W];
  assign cmd_onehot = NSECT'(1) << cmd_sect;
  assign cmd_hit    = mask_q[cmd_sect];
  assign rd_hit     = mask_q[rd_sect];
  assign sel_cnt    = CNT_W'($countones(mask_q));

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mask_q[g] <= 1'b0;
      else if (clear)                             mask_q[g] <= 1'b0;
      else if (add && cmd_sect == SECT_W'(g))     mask_q[g] <= 1'b1;
    end
  end

  // R6: an accepted erase command leaves its sector in the set
  assert_set_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clear) |=> ((mask_q & $past(cmd_onehot)) != '0));

  // R9: completion or reset empties the set
  assert_set_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sel_cnt == '0));

endmodule

// File: rtl/fsg_sequencer.sv
module fsg_sequencer
  import flash_status_pkg::*;
#(
  parameter int unsigned NSECT      = 8,
  parameter int unsigned ERASE_WIN  = 16,
  parameter int unsigned PGM_PULSES = 3,
  parameter int unsigned PGM_LIMIT  = 6,
  parameter int unsigned ERS_PULSES = 3,
  parameter int unsigned ERS_LIMIT  = 12
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_prog,
  input  logic   cmd_erase,
  input  logic   cmd_susp,
  input  logic   cmd_resume,
  input  logic   cmd_reset,
  input  logic   cmd_hit,
  input  logic [$clog2(NSECT+1)-1:0] sel_cnt,
  input  logic   pulse_tick,
  input  logic   tgt_blank,
  input  logic   pgm_bit7,
  output mode_t  mode,
  output logic   pgm_d7,
  output logic   fail_erase,
  output logic   set_add,
  output logic   set_clear
);
  localparam int unsigned WIN_W = $clog2(ERASE_WIN + 1);
  localparam int unsigned PC_W  = $clog2(PGM_LIMIT + 1);
  localparam int unsigned EC_W  = $clog2(ERS_LIMIT + 1);

  mode_t           mode_q;
  logic [WIN_W-1:0] win_q;
  logic [PC_W-1:0]  pcnt_q;
  logic [EC_W-1:0]  ecnt_q;
  logic             blank_q;
  logic             d7_q;
  logic             ferase_q;

  // Named internal events
  logic        pgm_active;
  logic        prog_done;
  logic        prog_fail;
  logic        ers_done;
  logic        ers_fail;
  logic        win_expire;
  logic        start_erase;
  logic        start_sprog;
  logic        do_reset;
  int unsigned ers_goal;

  assign pgm_active  = (mode_q == M_PROG) || (mode_q == M_SPROG);
  assign prog_done   = pgm_active && pulse_tick && blank_q &&
                       tick_hits(32'(pcnt_q), PGM_PULSES);
  assign prog_fail   = pgm_active && pulse_tick && !blank_q &&
                       tick_hits(32'(pcnt_q), PGM_LIMIT);
  assign ers_goal    = erase_need(32'(sel_cnt), ERS_PULSES);
  assign ers_done    = (mode_q == M_ERASE) && pulse_tick &&
                       tick_hits(32'(ecnt_q), ers_goal);
  assign ers_fail    = (mode_q == M_ERASE) && pulse_tick && !ers_done &&
                       tick_hits(32'(ecnt_q), ERS_LIMIT);
  assign win_expire  = (mode_q == M_EWIN) && !cmd_erase &&
                       (win_q == WIN_W'(ERASE_WIN - 1));
  assign start_erase = ((mode_q == M_IDLE) || (mode_q == M_EWIN)) && cmd_erase;
  assign start_sprog = (mode_q == M_SREAD) && cmd_prog && !cmd_hit && !cmd_resume;
  assign do_reset    = (mode_q == M_FAIL) && cmd_reset;

  assign set_add     = start_erase;
  assign set_clear   = ers_done || do_reset;
  assign mode        = mode_q;
  assign pgm_d7      = d7_q;
  assign fail_erase  = ferase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      win_q    <= '0;
      pcnt_q   <= '0;
      ecnt_q   <= '0;
      blank_q  <= 1'b0;
      d7_q     <= 1'b0;
      ferase_q <= 1'b0;
    end else begin
      case (mode_q)
        M_IDLE: begin
          if (start_erase) begin
            mode_q <= M_EWIN;
            win_q  <= '0;
          end else if (cmd_prog) begin
            mode_q  <= M_PROG;
            pcnt_q  <= '0;
            blank_q <= tgt_blank;
            d7_q    <= pgm_bit7;
          end
        end
        M_PROG: begin
          if (prog_done) begin
            mode_q <= M_IDLE;
          end else if (prog_fail) begin
            mode_q   <= M_FAIL;
            ferase_q <= 1'b0;
          end else if (pulse_tick) begin
            pcnt_q <= pcnt_q + PC_W'(1);
          end
        end
        M_EWIN: begin
          if (cmd_erase) begin
            win_q <= '0;
          end else if (win_expire) begin
            mode_q <= M_ERASE;
            ecnt_q <= '0;
          end else begin
            win_q <= win_q + WIN_W'(1);
          end
        end
        M_ERASE: begin
          if (ers_done) begin
            mode_q <= M_IDLE;
          end else if (ers_fail) begin
            mode_q   <= M_FAIL;
            ferase_q <= 1'b1;
          end else begin
            if (pulse_tick) ecnt_q <= ecnt_q + EC_W'(1);
            if (cmd_susp)   mode_q <= M_SREAD;
          end
        end
        M_SREAD: begin
          if (cmd_resume) begin
            mode_q <= M_ERASE;
          end else if (start_sprog) begin
            mode_q  <= M_SPROG;
            pcnt_q  <= '0;
            blank_q <= tgt_blank;
            d7_q    <= pgm_bit7;
          end
        end
        M_SPROG: begin
          if (prog_done) begin
            mode_q <= M_SREAD;
          end else if (prog_fail) begin
            mode_q   <= M_FAIL;
            ferase_q <= 1'b0;
          end else if (pulse_tick) begin
            pcnt_q <= pcnt_q + PC_W'(1);
          end
        end
        M_FAIL: begin
          if (do_reset) mode_q <= M_IDLE;
        end
        default: mode_q <= M_IDLE;
      endcase
    end
  end

  // R4: failure holds until a reset command
  assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FAIL && !cmd_reset) |=> (mode_q == M_FAIL));

  assert_fail_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_reset |=> (mode_q == M_IDLE));

  // R3: a limit hit on a program leads to the failure state
  assert_prog_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fail |=> (mode_q == M_FAIL && !ferase_q));

  // R6: a further erase command inside the window restarts it
  assert_win_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_EWIN && cmd_erase) |=> (mode_q == M_EWIN && win_q == '0));

  // R7: erase cannot be left except by suspend, completion or failure
  assert_erase_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ERASE && !cmd_susp && !ers_done && !ers_fail) |=> (mode_q == M_ERASE));

  // R12: resume re-enters erase with the pulse count untouched
  assert_resume_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SREAD && cmd_resume) |=> (mode_q == M_ERASE && $stable(ecnt_q)));

endmodule

// File: rtl/fsg_status_fmt.sv
module fsg_status_fmt
  import flash_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_t      mode,
  input  logic       rd_stb,
  input  logic       rd_hit,
  input  logic       pgm_d7,
  input  logic       fail_erase,
  input  logic [7:0] array_dout,
  output logic [7:0] stat_out,
  output logic       stat_vld
);
  logic       t6_q;
  logic       t2_q;
  logic [7:0] byte_c;
  logic       flip6;
  logic       flip2;

  always_comb begin
    byte_c = array_dout;
    flip6  = 1'b0;
    flip2  = 1'b0;
    case (mode)
      M_PROG: begin
        byte_c = pack_status(~pgm_d7, t6_q, 1'b0, 1'b0, 1'b1);
        flip6  = 1'b1;
      end
      M_EWIN: begin
        byte_c = pack_status(1'b0, t6_q, 1'b0, 1'b0, rd_hit ? t2_q : 1'b1);
        flip6  = 1'b1;
        flip2  = rd_hit;
      end
      M_ERASE: begin
        byte_c = pack_status(1'b0, t6_q, 1'b0, 1'b1, rd_hit ? t2_q : 1'b1);
        flip6  = 1'b1;
        flip2  = rd_hit;
      end
      M_SREAD: begin
        if (rd_hit) begin
          byte_c = pack_status(1'b1, t6_q, 1'b0, 1'b1, t2_q);
          flip2  = 1'b1;
        end
      end
      M_SPROG: begin
        byte_c = pack_status(~pgm_d7, t6_q, 1'b0, 1'b1, 1'b1);
        flip6  = 1'b1;
      end
      M_FAIL: begin
        byte_c = pack_status(fail_erase ? 1'b0 : ~pgm_d7, t6_q, 1'b1, 1'b0, 1'b0);
        flip6  = 1'b1;
      end
      default: byte_c = array_dout;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6_q     <= 1'b0;
      t2_q     <= 1'b0;
      stat_out <= '0;
      stat_vld <= 1'b0;
    end else begin
      stat_vld <= rd_stb;
      if (rd_stb) begin
        stat_out <= byte_c;
        if (flip6) t6_q <= ~t6_q;
        if (flip2) t2_q <= ~t2_q;
      end
    end
  end

  // R1: every read strobe yields a result on the next cycle, and only then
  assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> stat_vld);
  assert_vld_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !stat_vld);

  // R13: toggle state moves only with a read
  assert_tog_per_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(t6_q) && $stable(t2_q)));

  // R3: a read in the failure state reports the limit bit
  assert_limit_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode == M_FAIL) |=> stat_out[5]);

  // R10: suspended reads leave the bit-6 toggle still
  assert_sread_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode == M_SREAD) |=> $stable(t6_q));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned SECT_W     = 3,
  parameter int unsigned ERASE_WIN  = 16,
  parameter int unsigned PGM_PULSES = 3,
  parameter int unsigned PGM_LIMIT  = 6,
  parameter int unsigned ERS_PULSES = 3,
  parameter int unsigned ERS_LIMIT  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic              cmd_reset,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pgm_bit7,
  input  logic              tgt_blank,
  input  logic              pulse_tick,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_dout,
  output logic [7:0]        stat_out,
  output logic              stat_vld,
  output logic              busy
);
  localparam int unsigned NSECT = 1 << SECT_W;
  localparam int unsigned CNT_W = $clog2(NSECT + 1);

  mode_t            mode;
  logic             pgm_d7;
  logic             fail_erase;
  logic             set_add;
  logic             set_clear;
  logic             cmd_hit;
  logic             rd_hit;
  logic [CNT_W-1:0] sel_cnt;

  fsg_erase_set #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_set (
    .clk(clk), .rst_n(rst_n), .add(set_add), .clear(set_clear),
    .cmd_addr(cmd_addr), .rd_addr(rd_addr),
    .cmd_hit(cmd_hit), .rd_hit(rd_hit), .sel_cnt(sel_cnt)
  );

  fsg_sequencer #(
    .NSECT(NSECT), .ERASE_WIN(ERASE_WIN), .PGM_PULSES(PGM_PULSES),
    .PGM_LIMIT(PGM_LIMIT), .ERS_PULSES(ERS_PULSES), .ERS_LIMIT(ERS_LIMIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_susp(cmd_susp),
    .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
    .cmd_hit(cmd_hit), .sel_cnt(sel_cnt),
    .pulse_tick(pulse_tick), .tgt_blank(tgt_blank), .pgm_bit7(pgm_bit7),
    .mode(mode), .pgm_d7(pgm_d7), .fail_erase(fail_erase),
    .set_add(set_add), .set_clear(set_clear)
  );

  fsg_status_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_stb(rd_stb), .rd_hit(rd_hit),
    .pgm_d7(pgm_d7), .fail_erase(fail_erase), .array_dout(array_dout),
    .stat_out(stat_out), .stat_vld(stat_vld)
  );

  assign busy = (mode != M_IDLE) && (mode != M_SREAD);

  // R10: the read-enabled suspend releases the busy flag
  assert_susp_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && cmd_susp && !pulse_tick) |=> !busy);

endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] C_PROG  = 5'b10000;
  localparam logic [4:0] C_ERASE = 5'b01000;
  localparam logic [4:0] C_SUSP  = 5'b00100;
  localparam logic [4:0] C_RES   = 5'b00010;
  localparam logic [4:0] C_RST   = 5'b00001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_prog = 1'b0, cmd_erase = 1'b0, cmd_susp = 1'b0;
  logic        cmd_resume = 1'b0, cmd_reset = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic        pgm_bit7 = 1'b0, tgt_blank = 1'b0, pulse_tick = 1'b0;
  logic        rd_stb = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [7:0]  array_dout = '0;
  logic [7:0]  stat_out;
  logic        stat_vld;
  logic        busy;

  flash_status_gen dut (
    .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
    .cmd_addr(cmd_addr), .pgm_bit7(pgm_bit7), .tgt_blank(tgt_blank),
    .pulse_tick(pulse_tick), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .array_dout(array_dout), .stat_out(stat_out), .stat_vld(stat_vld),
    .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  logic  m6 = 1'b0;
  logic  m2 = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] arr_of(input logic [11:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // Monitor: compares each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && stat_vld) begin
      if (exp_q.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R1 unexpected result actual=%h expected=none", stat_out);
      end else begin
        check_val(stat_out, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic pulse_cmd(input logic [4:0] s, input logic [11:0] a,
                           input logic d7, input logic blank);
    {cmd_prog, cmd_erase, cmd_susp, cmd_resume, cmd_reset} = s;
    cmd_addr = a; pgm_bit7 = d7; tgt_blank = blank;
    @(negedge clk);
    {cmd_prog, cmd_erase, cmd_susp, cmd_resume, cmd_reset} = 5'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_tick = 1'b1;
      @(negedge clk);
    end
    pulse_tick = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_push(input logic [11:0] a, input logic [7:0] exp, input string tag);
    rd_stb = 1'b1; rd_addr = a; array_dout = arr_of(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic rd_array(input logic [11:0] a, input string tag);
    rd_push(a, arr_of(a), tag);
  endtask

  task automatic rd_prog(input logic [11:0] a, input logic d7, input logic susp, input string tag);
    logic [7:0] e;
    e = {~d7, m6, 1'b0, 1'b0, susp, 1'b1, 2'b00};
    m6 = ~m6;
    rd_push(a, e, tag);
  endtask

  task automatic rd_ers(input logic [11:0] a, input logic hit, input logic in_win, input string tag);
    logic [7:0] e;
    e = {1'b0, m6, 1'b0, 1'b0, ~in_win, hit ? m2 : 1'b1, 2'b00};
    m6 = ~m6;
    if (hit) m2 = ~m2;
    rd_push(a, e, tag);
  endtask

  task automatic rd_sus(input logic [11:0] a, input string tag);
    logic [7:0] e;
    e = {1'b1, m6, 1'b0, 1'b0, 1'b1, m2, 2'b00};
    m2 = ~m2;
    rd_push(a, e, tag);
  endtask

  task automatic rd_fail(input logic [11:0] a, input logic d7, input logic er, input string tag);
    logic [7:0] e;
    e = {er ? 1'b0 : ~d7, m6, 1'b1, 5'b00000};
    m6 = ~m6;
    rd_push(a, e, tag);
  endtask

  task automatic chk_busy(input logic exp, input string tag);
    check_val({7'b0, busy}, {7'b0, exp}, tag);
  endtask

  initial begin
    wait_cyc(3);
    // R1: reset state
    check_val(stat_out, 8'h00, "R1 stat_out in reset");
    check_val({7'b0, stat_vld}, 8'h00, "R1 stat_vld in reset");
    chk_busy(1'b0, "R1 busy in reset");
    rst_n = 1'b1;
    wait_cyc(1);
    rd_array(12'h010, "R1 idle read");

    // R2 and R13: blank program, reads spaced by idle cycles
    pulse_cmd(C_PROG, 12'h123, 1'b1, 1'b1);
    chk_busy(1'b1, "R2 busy during program");
    rd_prog(12'h123, 1'b1, 1'b0, "R2 program status");
    wait_cyc(3);
    rd_prog(12'h123, 1'b1, 1'b0, "R13 toggle after idle gap");
    wait_cyc(5);
    rd_prog(12'h7FF, 1'b1, 1'b0, "R13 toggle per read");
    ticks(2);
    chk_busy(1'b1, "R2 still programming");
    ticks(1);
    chk_busy(1'b0, "R2 program complete");
    rd_array(12'h123, "R2 data after program");

    // R3: non-blank program runs into the limit
    pulse_cmd(C_PROG, 12'h050, 1'b0, 1'b0);
    ticks(5);
    rd_prog(12'h050, 1'b0, 1'b0, "R3 before limit");
    ticks(1);
    chk_busy(1'b1, "R3 busy after limit");
    rd_fail(12'h050, 1'b0, 1'b0, "R3 limit status");
    rd_fail(12'h050, 1'b0, 1'b0, "R3 limit status toggles");
    // R4: lock until reset
    pulse_cmd(C_PROG, 12'h060, 1'b1, 1'b1);
    pulse_cmd(C_ERASE, 12'h400, 1'b0, 1'b0);
    chk_busy(1'b1, "R4 locked after commands");
    rd_fail(12'h060, 1'b0, 1'b0, "R4 commands ignored");
    pulse_cmd(C_RST, 12'h000, 1'b0, 1'b0);
    chk_busy(1'b0, "R4 reset releases");
    rd_array(12'h060, "R4 data after reset");

    // R5, R6, R8: erase window
    pulse_cmd(C_ERASE, 12'h400, 1'b0, 1'b0);
    rd_ers(12'h400, 1'b1, 1'b1, "R5 window selected sector");
    rd_ers(12'hA00, 1'b0, 1'b1, "R8 window other sector");
    chk_busy(1'b1, "R5 busy in window");
    wait_cyc(8);
    pulse_cmd(C_ERASE, 12'h800, 1'b0, 1'b0);
    wait_cyc(13);
    rd_ers(12'h800, 1'b1, 1'b1, "R6 window restarted");
    wait_cyc(4);
    rd_ers(12'h400, 1'b1, 1'b0, "R5 erase begun");
    rd_ers(12'hA00, 1'b0, 1'b0, "R8 erase other sector");
    rd_ers(12'h800, 1'b1, 1'b0, "R8 erase added sector");

    // R7: commands ignored during erase
    pulse_cmd(C_PROG, 12'hA10, 1'b1, 1'b1);
    pulse_cmd(C_RST, 12'h000, 1'b0, 1'b0);
    rd_ers(12'hA10, 1'b0, 1'b0, "R7 program ignored");
    chk_busy(1'b1, "R7 still erasing");

    // R10: suspend
    ticks(2);
    pulse_cmd(C_SUSP, 12'h000, 1'b0, 1'b0);
    chk_busy(1'b0, "R10 suspend not busy");
    rd_sus(12'h400, "R10 suspended sector");
    rd_sus(12'h810, "R10 suspended sector again");
    rd_array(12'hA20, "R10 other sector data");

    // R11: program during suspend
    pulse_cmd(C_PROG, 12'h830, 1'b1, 1'b1);
    chk_busy(1'b0, "R11 program to selected ignored");
    pulse_cmd(C_PROG, 12'hC40, 1'b1, 1'b1);
    chk_busy(1'b1, "R11 suspended program busy");
    rd_prog(12'hC40, 1'b1, 1'b1, "R11 suspended program status");
    ticks(3);
    chk_busy(1'b0, "R11 back to suspend");
    rd_sus(12'h400, "R11 suspend status restored");

    // R12 and R9: resume then completion
    pulse_cmd(C_RES, 12'h000, 1'b0, 1'b0);
    chk_busy(1'b1, "R12 resumed");
    ticks(3);
    chk_busy(1'b1, "R12 count preserved");
    ticks(1);
    chk_busy(1'b0, "R9 erase complete");
    rd_array(12'h400, "R9 data after erase");

    // R9: erase exceeding the limit
    for (int s = 0; s < 5; s++) pulse_cmd(C_ERASE, 12'(s << 9), 1'b0, 1'b0);
    wait_cyc(20);
    ticks(11);
    chk_busy(1'b1, "R9 before erase limit");
    ticks(1);
    rd_fail(12'h200, 1'b0, 1'b1, "R9 erase limit status");
    chk_busy(1'b1, "R9 busy after erase limit");
    pulse_cmd(C_RST, 12'h000, 1'b0, 1'b0);
    chk_busy(1'b0, "R4 reset after erase failure");
    rd_array(12'h200, "R4 data after erase failure");

    wait_cyc(3);
    if (exp_q.size() != 0) begin
      n_vec++;
      n_bad++;
      $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule